// File: doc/BRIEF.md
# SCSI Controller Command Register Unit

This unit is the byte-wide register file of a SCSI protocol controller. A host reaches it over a plain register bus. The word index is taken from address bits [ADDR_W-1:2], and the two low address bits are ignored. Each host write is stored in a write-side array. Host reads come from a separate read-side array that holds status, interrupt status, sequence step and a revision byte.

A write to the command slot (index 3) starts an operation. Bits [6:0] of the written byte select the operation, and bit 7 is ignored. Each operation loads fixed status, interrupt and sequence codes into the read-side array, and most of them raise a sticky interrupt.

Select-with-attention is handled in two ways. If the target is missing, the unit reports a disconnect at once. If the target is present, the unit issues a one-cycle request to an external command-descriptor engine, with the target number and the 16-bit transfer length. It then waits for that engine to return done or fail. Completion of every operation is a single-cycle status update.

Top module: `scsi_cmd_regfile`

## Requirements
- R1: The register index is address bits [5:2], and address bits [1:0] have no effect. A write updates only the write-side array, so write-side index 0 reads back through the read side as 0x00. `desc_tgt` is bits [2:0] of write index 4. `desc_len` is write index 1 in bits [15:8] and write index 0 in bits [7:0].
- R2: After reset, read index 14 holds 0x04 and every other read index holds 0x00. `irq` and `desc_req` are low.
- R3: Opcode 0x01 (flush) sets interrupt status (read 5) to 0x08 and sequence (read 6) to 0x00. It leaves status (read 4) and `irq` unchanged.
- R4: Opcodes 0x00, 0x03 and every opcode not listed in R3, R5 to R9 leave the read-side array and `irq` unchanged.
- R5: Opcode 0x02 (chip reset) clears the read-side array, reloads read index 14 with 0x04, and leaves `irq` unchanged.
- R6: Opcodes 0x42 and 0x43 (select) check the target number from R1. When that number is above NUM_TGT-1, or its bit in `tgt_present` is 0, the unit sets status 0x80, interrupt 0x20 and sequence 0x00, raises `irq`, and does not pulse `desc_req`.
- R7: A select to a present target drives `desc_req` high for exactly one cycle, starting in the cycle after the command write, and the unit then waits. On `desc_done` it sets status 0x91, interrupt 0x18 and sequence 0x04. On `desc_fail` it sets status 0x80, interrupt 0x20 and sequence 0x00, with fail taking priority over done. Either return raises `irq`.
- R8: Opcode 0x10 (transfer information) sets status 0x93, interrupt 0x10 and sequence 0x00, and raises `irq`.
- R9: Opcode 0x11 sets status 0x93, interrupt 0x18 and sequence 0x04. Opcode 0x12 sets status 0x93, interrupt 0x20 and sequence 0x00. Both raise `irq`.
- R10: `irq` stays high until `irq_clr` is asserted. When a raise and a clear fall in the same cycle, the raise wins.
- R11: While the unit waits for the engine, command writes are stored on the write side but not executed.
- R12: Bit 7 of the command byte has no effect on which operation runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read-side register at the addressed index |
| tgt_present | input | NUM_TGT | One bit per target number, 1 = device present |
| desc_req | output | 1 | One-cycle request to the command-descriptor engine |
| desc_tgt | output | 3 | Target number for the request |
| desc_len | output | 16 | Transfer length for the request |
| desc_done | input | 1 | Engine finished successfully |
| desc_fail | input | 1 | Engine failed |
| irq_clr | input | 1 | Clears the interrupt |
| irq | output | 1 | Sticky interrupt request |

## Verification
The bench builds the unit with the defaults ADDR_W = 6 and NUM_TGT = 5. That gives sixteen register indices, so the revision byte at index 14 can be reached. Target numbers 5 to 7 are encodable but lie beyond the mask, which exercises the out-of-range disconnect path next to the mask-bit-zero path. Random target numbers, masks, lengths, opcodes with a random bit 7, and engine returns are mixed with directed cases: a command issued while the unit waits, a raise and a clear in the same cycle, and a command address with nonzero low bits.

// File: rtl/scsi_ctl_pkg.sv
package scsi_ctl_pkg;

  localparam int CMD_IDX   = 3;
  localparam int TGT_IDX   = 4;
  localparam int LENLO_IDX = 0;
  localparam int LENHI_IDX = 1;
  localparam int STAT_IDX  = 4;
  localparam int INTR_IDX  = 5;
  localparam int SEQ_IDX   = 6;
  localparam int REV_IDX   = 14;
  localparam logic [7:0] REV_VAL = 8'h04;

  // status byte pieces
  localparam logic [7:0] ST_PH_DIN  = 8'h01;
  localparam logic [7:0] ST_PH_STAT = 8'h03;
  localparam logic [7:0] ST_TCNT    = 8'h10;
  localparam logic [7:0] ST_IRQ     = 8'h80;
  // interrupt byte pieces
  localparam logic [7:0] IN_FDONE = 8'h08;
  localparam logic [7:0] IN_BSVC  = 8'h10;
  localparam logic [7:0] IN_DISC  = 8'h20;

  typedef enum logic [2:0] {
    ACT_NONE,
    ACT_FLUSH,
    ACT_CHIPRST,
    ACT_POST,
    ACT_SELECT
  } act_e;

  typedef struct packed {
    logic [7:0] st;
    logic [7:0] intr;
    logic [7:0] seq;
  } codes_t;

  localparam codes_t CODES_DISC = '{st: ST_IRQ, intr: IN_DISC, seq: 8'h00};
  localparam codes_t CODES_SEL  = '{st: ST_IRQ | ST_TCNT | ST_PH_DIN,
                                    intr: IN_BSVC | IN_FDONE, seq: 8'h04};

endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_ctl_pkg::*;
(
  input  logic [6:0] op_i,
  output act_e       act_o,
  output codes_t     codes_o
);

  always_comb begin
    act_o   = ACT_NONE;
    codes_o = '0;
    unique case (op_i)
      7'h01: begin
        act_o        = ACT_FLUSH;
        codes_o.intr = IN_FDONE;
      end
      7'h02: act_o = ACT_CHIPRST;
      7'h10: begin
        act_o   = ACT_POST;
        codes_o = '{st: ST_IRQ | ST_TCNT | ST_PH_STAT, intr: IN_BSVC, seq: 8'h00};
      end
      7'h11: begin
        act_o   = ACT_POST;
        codes_o = '{st: ST_IRQ | ST_TCNT | ST_PH_STAT, intr: IN_BSVC | IN_FDONE, seq: 8'h04};
      end
      7'h12: begin
        act_o   = ACT_POST;
        codes_o = '{st: ST_IRQ | ST_TCNT | ST_PH_STAT, intr: IN_DISC, seq: 8'h00};
      end
      7'h42, 7'h43: begin
        act_o   = ACT_SELECT;
        codes_o = CODES_SEL;
      end
      default: act_o = ACT_NONE;
    endcase
  end

endmodule

// File: rtl/scsi_wr_bank.sv
module scsi_wr_bank #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [7:0]       wdata_i,
  output logic [2:0]       tgt_o,
  output logic [15:0]      len_o
);
  import scsi_ctl_pkg::*;

  localparam int NUM_REGS = 1 << IDX_W;

  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_wreg
    logic [7:0] r_q;
    logic       r_en;
    assign r_en = we_i && (idx_i == IDX_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    r_q <= 8'h00;
      else if (r_en) r_q <= wdata_i;
    end
    assign regs[g] = r_q;
  end

  assign tgt_o = regs[TGT_IDX][2:0];
  assign len_o = {regs[LENHI_IDX], regs[LENLO_IDX]};

endmodule

// File: rtl/scsi_rd_bank.sv
module scsi_rd_bank #(
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ld_st_i,
  input  logic             ld_int_i,
  input  logic             ld_seq_i,
  input  scsi_ctl_pkg::codes_t codes_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [7:0]       rd_data_o,
  output logic [7:0]       st_o
);
  import scsi_ctl_pkg::*;

  localparam int NUM_REGS = 1 << IDX_W;

  logic [7:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_rreg
    localparam logic [7:0] RST_V = (g == REV_IDX) ? REV_VAL : 8'h00;
    logic [7:0] r_q, r_d;
    logic       r_en;

    always_comb begin
      r_en = clr_i;
      r_d  = RST_V;
      if (!clr_i) begin
        if (g == STAT_IDX && ld_st_i) begin
          r_en = 1'b1;
          r_d  = codes_i.st;
        end
        if (g == INTR_IDX && ld_int_i) begin
          r_en = 1'b1;
          r_d  = codes_i.intr;
        end
        if (g == SEQ_IDX && ld_seq_i) begin
          r_en = 1'b1;
          r_d  = codes_i.seq;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    r_q <= RST_V;
      else if (r_en) r_q <= r_d;
    end

    assign regs[g] = r_q;
  end

  assign rd_data_o = regs[rd_idx_i];
  assign st_o      = regs[STAT_IDX];

endmodule

// File: rtl/scsi_cmd_regfile.sv
module scsi_cmd_regfile
  import scsi_ctl_pkg::*;
#(
  parameter int ADDR_W  = 6,
  parameter int NUM_TGT = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [7:0]         bus_wdata,
  output logic [7:0]         bus_rdata,
  input  logic [NUM_TGT-1:0] tgt_present,
  output logic               desc_req,
  output logic [2:0]         desc_tgt,
  output logic [15:0]        desc_len,
  input  logic               desc_done,
  input  logic               desc_fail,
  input  logic               irq_clr,
  output logic               irq
);

  localparam int IDX_W = ADDR_W - 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic [IDX_W-1:0] idx;
  logic             busy_q, busy_d, req_q, req_d, irq_q, irq_d;
  logic             cmd_wr, tgt_ok, irq_set;
  logic             clr, ld_st, ld_int, ld_seq;
  act_e             act;
  codes_t           dec_codes, codes;
  logic [7:0]       st_cur;

  assign idx    = bus_addr[ADDR_W-1:2];
  assign cmd_wr = bus_we && (idx == IDX_W'(CMD_IDX)) && !busy_q;

  scsi_cmd_decode u_dec (
    .op_i    (bus_wdata[6:0]),
    .act_o   (act),
    .codes_o (dec_codes)
  );

  scsi_wr_bank #(.IDX_W(IDX_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .we_i    (bus_we),
    .idx_i   (idx),
    .wdata_i (bus_wdata),
    .tgt_o   (desc_tgt),
    .len_o   (desc_len)
  );

  always_comb begin
    tgt_ok = 1'b0;
    for (int i = 0; i < NUM_TGT; i++) begin
      if (desc_tgt == 3'(i) && tgt_present[i]) tgt_ok = 1'b1;
    end
  end

  // next-state
  always_comb begin
    clr     = 1'b0;
    ld_st   = 1'b0;
    ld_int  = 1'b0;
    ld_seq  = 1'b0;
    irq_set = 1'b0;
    req_d   = 1'b0;
    busy_d  = busy_q;
    codes   = dec_codes;
    if (busy_q) begin
      if (desc_fail || desc_done) begin
        codes   = desc_fail ? CODES_DISC : CODES_SEL;
        {ld_st, ld_int, ld_seq} = 3'b111;
        irq_set = 1'b1;
        busy_d  = 1'b0;
      end
    end else if (cmd_wr) begin
      unique case (act)
        ACT_FLUSH:   {ld_int, ld_seq} = 2'b11;
        ACT_CHIPRST: clr = 1'b1;
        ACT_POST: begin
          {ld_st, ld_int, ld_seq} = 3'b111;
          irq_set = 1'b1;
        end
        ACT_SELECT: begin
          if (tgt_ok) begin
            req_d  = 1'b1;
            busy_d = 1'b1;
          end else begin
            codes   = CODES_DISC;
            {ld_st, ld_int, ld_seq} = 3'b111;
            irq_set = 1'b1;
          end
        end
        default: ;
      endcase
    end
    irq_d = irq_set ? 1'b1 : (irq_clr ? 1'b0 : irq_q);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      busy_q <= 1'b0;
      req_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      req_q  <= req_d;
      irq_q  <= irq_d;
    end
  end

  scsi_rd_bank #(.IDX_W(IDX_W)) u_rd (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .clr_i     (clr),
    .ld_st_i   (ld_st),
    .ld_int_i  (ld_int),
    .ld_seq_i  (ld_seq),
    .codes_i   (codes),
    .rd_idx_i  (idx),
    .rd_data_o (bus_rdata),
    .st_o      (st_cur)
  );

  assign desc_req = req_q;
  assign irq      = irq_q;

  // R7
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    desc_req |=> !desc_req);

  // R7
  req_waits_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    desc_req |-> busy_q);

  // R10
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    irq && !irq_clr |=> irq);

  // R6
  irq_status_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(irq) |-> st_cur[7]);

  // R5
  chip_reset_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !busy_q && bus_we && idx == IDX_W'(CMD_IDX) && bus_wdata[6:0] == 7'h02
    |=> st_cur == 8'h00);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    busy_q && !desc_done && !desc_fail |=> $stable(st_cur));

endmodule

// File: tb/scsi_cmd_regfile_tb.sv
module scsi_cmd_regfile_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  bus_addr;
  logic        bus_we;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [4:0]  tgt_present;
  logic        desc_req;
  logic [2:0]  desc_tgt;
  logic [15:0] desc_len;
  logic        desc_done, desc_fail, irq_clr, irq;

  always #5 clk = ~clk;

  scsi_cmd_regfile dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tgt_present(tgt_present),
    .desc_req(desc_req), .desc_tgt(desc_tgt), .desc_len(desc_len),
    .desc_done(desc_done), .desc_fail(desc_fail), .irq_clr(irq_clr), .irq(irq)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0]  e_st, e_int, e_seq;
  logic        e_irq;
  logic [2:0]  b_tgt;
  logic [15:0] b_len;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr_raw(input logic [5:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [7:0] d);
    wr_raw({idx, 2'b00}, d);
  endtask

  task automatic peek(input logic [3:0] idx, output logic [7:0] v);
    bus_addr = {idx, 2'b00};
    #1;
    v = bus_rdata;
  endtask

  task automatic check_regs(input string tag);
    logic [7:0] v;
    peek(4'd4, v);  chk({tag, " status"}, v, e_st);
    peek(4'd5, v);  chk({tag, " intr"}, v, e_int);
    peek(4'd6, v);  chk({tag, " seq"}, v, e_seq);
    peek(4'd14, v); chk({tag, " rev"}, v, 8'h04);
    chk({tag, " irq"}, irq, e_irq);
  endtask

  task automatic set_codes(input logic [7:0] s, input logic [7:0] i, input logic [7:0] q);
    e_st = s; e_int = i; e_seq = q; e_irq = 1'b1;
  endtask

  task automatic setup(input logic [7:0] t, input logic [15:0] len);
    wr(4'd4, t); wr(4'd0, len[7:0]); wr(4'd1, len[15:8]);
    b_tgt = t[2:0]; b_len = len;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    e_irq = 1'b0;
  endtask

  function automatic logic present(input logic [2:0] t, input logic [4:0] m);
    return (t < 3'd5) && m[t];
  endfunction

  // resp: 0 done, 1 fail, 2 both (fail wins)
  task automatic run_cmd(input logic [6:0] op, input logic b7, input int resp, input string tag);
    wr(4'd3, {b7, op});
    case (op)
      7'h01: begin e_int = 8'h08; e_seq = 8'h00; end                  // R3
      7'h02: begin e_st = 8'h00; e_int = 8'h00; e_seq = 8'h00; end    // R5
      7'h10: set_codes(8'h93, 8'h10, 8'h00);                          // R8
      7'h11: set_codes(8'h93, 8'h18, 8'h04);                          // R9
      7'h12: set_codes(8'h93, 8'h20, 8'h00);                          // R9
      7'h42, 7'h43: begin
        if (present(b_tgt, tgt_present)) begin
          chk({tag, " R7 req"}, desc_req, 1);
          chk({tag, " R1 tgt"}, desc_tgt, b_tgt);
          chk({tag, " R1 len"}, desc_len, b_len);
          desc_done = (resp != 1); desc_fail = (resp != 0);
          @(negedge clk);
          desc_done = 1'b0; desc_fail = 1'b0;
          chk({tag, " R7 req low"}, desc_req, 0);
          if (resp == 0) set_codes(8'h91, 8'h18, 8'h04);
          else           set_codes(8'h80, 8'h20, 8'h00);
        end else begin
          chk({tag, " R6 no req"}, desc_req, 0);
          set_codes(8'h80, 8'h20, 8'h00);
        end
      end
      default: ;                                                       // R4
    endcase
    check_regs(tag);
  endtask

  bit done_flag = 1'b0;

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [6:0] ops [10] = '{7'h00, 7'h01, 7'h02, 7'h03, 7'h10, 7'h11,
                             7'h12, 7'h42, 7'h43, 7'h1a};
    void'($urandom(32'd1234));
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0;
    tgt_present = '0; desc_done = 1'b0; desc_fail = 1'b0; irq_clr = 1'b0;
    e_st = 0; e_int = 0; e_seq = 0; e_irq = 0; b_tgt = 0; b_len = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 reset state
    check_regs("R2 reset");
    chk("R2 desc_req", desc_req, 0);

    // R1: write-side value not visible on read side
    wr(4'd0, 8'h5a);
    peek(4'd0, v); chk("R1 read0", v, 8'h00);

    // R7 select, engine done
    tgt_present = 5'b00100;
    setup(8'hfa, 16'h0203);
    run_cmd(7'h42, 1'b0, 0, "R7 sel done");
    clear_irq();
    check_regs("R10 clear");

    // R7 engine fail, and fail over done
    run_cmd(7'h43, 1'b0, 1, "R7 sel fail");
    run_cmd(7'h42, 1'b0, 2, "R7 sel both");

    // R6 out of range and mask bit zero
    setup(8'h05, 16'h0010);
    run_cmd(7'h42, 1'b0, 0, "R6 id5");
    setup(8'h01, 16'h0010);
    run_cmd(7'h43, 1'b0, 0, "R6 absent");

    // R3 flush with bit7 (R12)
    run_cmd(7'h10, 1'b0, 0, "R8 ti");
    clear_irq();
    run_cmd(7'h01, 1'b1, 0, "R3 R12 flush");
    run_cmd(7'h11, 1'b1, 0, "R9 R12 cc");
    run_cmd(7'h12, 1'b0, 0, "R9 msgacc");
    clear_irq();

    // R4 no-effect opcodes
    run_cmd(7'h00, 1'b0, 0, "R4 nop");
    run_cmd(7'h03, 1'b1, 0, "R4 busrst");
    run_cmd(7'h1a, 1'b0, 0, "R4 other");

    // R11 commands ignored while waiting
    tgt_present = 5'b11111;
    setup(8'h03, 16'hbeef);
    wr(4'd3, 8'h42);
    chk("R11 req", desc_req, 1);
    wr(4'd3, 8'h10);
    wr(4'd3, 8'h02);
    check_regs("R11 busy");
    @(negedge clk); desc_done = 1'b1;
    @(negedge clk); desc_done = 1'b0;
    set_codes(8'h91, 8'h18, 8'h04);
    check_regs("R11 after");

    // R5 chip reset keeps irq
    run_cmd(7'h02, 1'b0, 0, "R5 chiprst");

    // R10 raise wins over clear
    @(negedge clk);
    bus_addr = {4'd3, 2'b00}; bus_wdata = 8'h10; bus_we = 1'b1; irq_clr = 1'b1;
    @(negedge clk);
    bus_we = 1'b0; irq_clr = 1'b0;
    set_codes(8'h93, 8'h10, 8'h00);
    check_regs("R10 set wins");

    // R1 low address bits ignored
    wr_raw({4'd3, 2'b11}, 8'h11);
    set_codes(8'h93, 8'h18, 8'h04);
    check_regs("R1 lowbits");

    // random mix
    for (int it = 0; it < 400; it++) begin
      tgt_present = 5'($urandom);
      setup(8'($urandom), 16'($urandom));
      if ($urandom_range(0, 3) == 0) clear_irq();
      run_cmd(ops[$urandom_range(0, 9)], 1'($urandom), int'($urandom_range(0, 2)), "rand");
    end

    done_flag = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule